// File: doc/BRIEF.md
# Stride Pattern-Matching Prefetch Generator

This block turns one demand access into a short, ordered burst of prefetch line addresses. It receives a footprint map covering three adjacent zones (the zone below the demand's zone, the demand's own zone and the zone above), with two bits of state for every cache line. It also receives the demand's line address. Every stride is tested at once. A forward candidate at distance N exists when the two lines N and 2N below the demand were both touched. A backward candidate exists when the two lines N and 2N above were both touched. A candidate is kept only if the target line is still untouched.

The detected candidates are captured in a register when the demand is accepted. Two priority encoders then drain that register nearest-first, at most two addresses per cycle, until the degree limit captured with the demand has been spent. A new demand replaces whatever is left of the previous set. Map storage, zone replacement and the policy that chooses the degree belong to neighbouring blocks.

Top module: `spf_gen`

## Requirements
- R1: After reset, and before the first accepted demand, `req0_valid_o` and `req1_valid_o` stay 0.
- R2: Line `i` of the window lives in `zone_map_i[2*i+1:2*i]`, where window index 0 is the first line of the lower zone. The demand sits at index `ZL + dmd_line_i[log2(ZL)-1:0]`. The 2-bit state codes are 00 untouched, 01 prefetched, 10 touched and 11 touched-after-prefetch. For stride N, the line at demand+N is a forward candidate when the lines at demand-N and demand-2N are both 10 or 11.
- R3: For stride N, the line at demand-N is a backward candidate when the lines at demand+N and demand+2N are both 10 or 11.
- R4: A candidate is produced only when its target line holds code 00.
- R5: When `pf_as_acc_i` is 1 at the demand, code 01 also counts as touched for the two source lines. When it is 0, code 01 does not count.
- R6: Candidates are issued in increasing stride. In a cycle with two requests, `req0` carries the smaller stride.
- R7: The first requests appear in the cycle after the demand is accepted. Each later cycle issues the next one or two.
- R8: The total number of requests issued for one demand never exceeds `degree_i` as sampled with that demand. A degree of 0 issues nothing.
- R9: Accepting a new demand discards every candidate still held from the previous one. Only the new set is issued afterwards.
- R10: A source line that falls outside the three-zone window never matches, so strides whose -2N or +2N line leaves the window produce no candidate.
- R11: A request address equals the demand line plus the stride (forward) or minus the stride (backward), modulo 2^26.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dmd_valid_i | input | 1 | A demand is presented this cycle |
| dmd_line_i | input | 26 | Line address of the demand |
| zone_map_i | input | 96 | Three-zone state map, 2 bits per line |
| pf_as_acc_i | input | 1 | Count prefetched lines as touched when matching |
| degree_i | input | 4 | Maximum requests for this demand |
| req0_valid_o | output | 1 | Nearer request valid |
| req0_line_o | output | 26 | Nearer request line address |
| req1_valid_o | output | 1 | Farther request valid |
| req1_line_o | output | 26 | Farther request line address |

## Verification
Issuing leftover candidates and capturing a fresh demand can land in the same cycle. The bench provokes this by presenting a second demand in the very cycle the first pair of the earlier burst is on the outputs. It then judges the result by requiring that exactly the new demand's candidates follow, with none of the earlier burst remaining. The degree limit and the two-per-cycle drain also meet in one cycle when an odd budget ends mid-pair. That case is judged by checking that `req1` drops while `req0` is still issued.

// File: rtl/spf_pkg.sv
package spf_pkg;
    typedef enum logic [1:0] {
        LS_IDLE  = 2'b00,
        LS_PREF  = 2'b01,
        LS_TOUCH = 2'b10,
        LS_HIT   = 2'b11
    } line_st_e;
endpackage

// File: rtl/spf_match.sv
module spf_match #(
    parameter int ZL = 16
) (
    input  logic [2*3*ZL-1:0]      map_i,
    input  logic [$clog2(ZL)-1:0]  off_i,
    input  logic                   pf_as_acc_i,
    output logic [2*ZL-1:0]        cand_o
);
    import spf_pkg::*;
    localparam int W  = 3 * ZL;
    localparam int PW = $clog2(W);

    logic [PW-1:0]  pos;
    logic [2*W-1:0] map_rev;
    logic [2*W-1:0] ahead_st;
    logic [2*W-1:0] behind_st;
    logic [W-1:0]   ahead_v;
    logic [W-1:0]   behind_v;

    function automatic logic touched(input logic [1:0] s, input logic pf);
        return s[1] | (pf & (s == LS_PREF));
    endfunction

    assign pos = PW'(ZL) + PW'(off_i);

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign map_rev[2*i +: 2] = map_i[2*(W-1-i) +: 2];
    end

    // Upward shifter: index k is the line k above the demand.
    assign ahead_st  = map_i >> {pos, 1'b0};
    assign ahead_v   = {W{1'b1}} >> pos;
    // Downward shifter: index k is the line k below the demand.
    assign behind_st = map_rev >> {PW'(W - 1) - pos, 1'b0};
    assign behind_v  = {W{1'b1}} >> (PW'(W - 1) - pos);

    for (genvar n = 1; n <= ZL; n++) begin : g_stride
        assign cand_o[2*(n-1)] = behind_v[n] & behind_v[2*n]
                               & touched(behind_st[2*n +: 2], pf_as_acc_i)
                               & touched(behind_st[4*n +: 2], pf_as_acc_i)
                               & ahead_v[n] & (ahead_st[2*n +: 2] == LS_IDLE);
        assign cand_o[2*(n-1)+1] = ahead_v[n] & ahead_v[2*n]
                                 & touched(ahead_st[2*n +: 2], pf_as_acc_i)
                                 & touched(ahead_st[4*n +: 2], pf_as_acc_i)
                                 & behind_v[n] & (behind_st[2*n +: 2] == LS_IDLE);
    end
endmodule

// File: rtl/spf_pick.sv
module spf_pick #(
    parameter int C = 32
) (
    input  logic [C-1:0]         vec_i,
    output logic                 v0_o,
    output logic [$clog2(C)-1:0] i0_o,
    output logic                 v1_o,
    output logic [$clog2(C)-1:0] i1_o
);
    localparam int IW = $clog2(C);

    always_comb begin
        v0_o = 1'b0;
        v1_o = 1'b0;
        i0_o = '0;
        i1_o = '0;
        for (int i = 0; i < C; i++) begin
            if (vec_i[i] && !v0_o) begin
                v0_o = 1'b1;
                i0_o = IW'(i);
            end else if (vec_i[i] && !v1_o) begin
                v1_o = 1'b1;
                i1_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/spf_gen.sv
module spf_gen #(
    parameter int LINE_W = 26,
    parameter int ZL     = 16,
    parameter int DEG_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dmd_valid_i,
    input  logic [LINE_W-1:0]      dmd_line_i,
    input  logic [2*3*ZL-1:0]      zone_map_i,
    input  logic                   pf_as_acc_i,
    input  logic [DEG_W-1:0]       degree_i,
    output logic                   req0_valid_o,
    output logic [LINE_W-1:0]      req0_line_o,
    output logic                   req1_valid_o,
    output logic [LINE_W-1:0]      req1_line_o
);
    localparam int ZB = $clog2(ZL);
    localparam int C  = 2 * ZL;
    localparam int IW = $clog2(C);
    localparam int SW = $clog2(ZL + 1);

    typedef struct packed {
        logic [C-1:0]      cand;
        logic [LINE_W-1:0] base;
        logic [DEG_W-1:0]  left;
    } gen_st_t;

    gen_st_t st_d, st_q;

    logic [C-1:0]  match_vec;
    logic          v0, v1, iss0, iss1;
    logic [IW-1:0] i0, i1;
    logic [SW-1:0] dist0, dist1;

    spf_match #(.ZL(ZL)) u_match (
        .map_i       (zone_map_i),
        .off_i       (dmd_line_i[ZB-1:0]),
        .pf_as_acc_i (pf_as_acc_i),
        .cand_o      (match_vec)
    );

    spf_pick #(.C(C)) u_pick (
        .vec_i (st_q.cand),
        .v0_o  (v0),
        .i0_o  (i0),
        .v1_o  (v1),
        .i1_o  (i1)
    );

    assign iss0  = v0 && (st_q.left != '0);
    assign iss1  = v1 && (st_q.left > DEG_W'(1));
    assign dist0 = SW'(i0 >> 1) + SW'(1);
    assign dist1 = SW'(i1 >> 1) + SW'(1);

    assign req0_valid_o = iss0;
    assign req1_valid_o = iss1;
    assign req0_line_o  = i0[0] ? st_q.base - LINE_W'(dist0) : st_q.base + LINE_W'(dist0);
    assign req1_line_o  = i1[0] ? st_q.base - LINE_W'(dist1) : st_q.base + LINE_W'(dist1);

    always_comb begin
        st_d = st_q;
        if (dmd_valid_i) begin
            st_d.cand = match_vec;
            st_d.base = dmd_line_i;
            st_d.left = degree_i;
        end else begin
            st_d.cand = st_q.cand & ~(C'(iss0) << i0) & ~(C'(iss1) << i1);
            st_d.left = st_q.left - DEG_W'(iss0) - DEG_W'(iss1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spf_gen_chk.sv
module spf_gen_chk #(
    parameter int LINE_W = 26,
    parameter int DEG_W  = 4,
    parameter int SW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dmd_valid_i,
    input logic [DEG_W-1:0]  degree_i,
    input logic              req0_valid_o,
    input logic              req1_valid_o,
    input logic [LINE_W-1:0] req0_line_o,
    input logic [LINE_W-1:0] req1_line_o,
    input logic [SW-1:0]     dist0,
    input logic [SW-1:0]     dist1
);
    logic [DEG_W:0]   issued_q;
    logic [DEG_W-1:0] budget_q;
    logic             seen_q;
    logic [DEG_W:0]   issued_now;

    assign issued_now = issued_q + (DEG_W+1)'(req0_valid_o) + (DEG_W+1)'(req1_valid_o);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued_q <= '0;
            budget_q <= '0;
            seen_q   <= 1'b0;
        end else if (dmd_valid_i) begin
            issued_q <= '0;
            budget_q <= degree_i;
            seen_q   <= 1'b1;
        end else begin
            issued_q <= issued_now;
        end
    end

    AST_QUIET_UNTIL_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !req0_valid_o && !req1_valid_o); // R1

    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        req1_valid_o |-> req0_valid_o && (dist0 < dist1) && (req0_line_o != req1_line_o)); // R6

    AST_NEAREST_ACROSS_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        (req0_valid_o && !$past(dmd_valid_i) && $past(req1_valid_o)) |-> dist0 > $past(dist1)); // R6

    AST_DEGREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        issued_now <= {1'b0, budget_q}); // R8
endmodule

bind spf_gen spf_gen_chk #(.LINE_W(LINE_W), .DEG_W(DEG_W), .SW(SW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dmd_valid_i  (dmd_valid_i),
    .degree_i     (degree_i),
    .req0_valid_o (req0_valid_o),
    .req1_valid_o (req1_valid_o),
    .req0_line_o  (req0_line_o),
    .req1_line_o  (req1_line_o),
    .dist0        (dist0),
    .dist1        (dist1)
);

// File: tb/spf_gen_tb.sv
`timescale 1ns/1ps
module spf_gen_tb;
    localparam int LW = 26;
    localparam int ZL = 16;
    localparam int W  = 3 * ZL;
    localparam int DW = 4;

    typedef logic [LW-1:0] lq_t[$];

    logic            clk = 1'b0;
    logic            rst_n;
    logic            dmd_valid;
    logic [LW-1:0]   dmd_line;
    logic [2*W-1:0]  zmap;
    logic            pf_acc;
    logic [DW-1:0]   degree;
    logic            r0v, r1v;
    logic [LW-1:0]   r0l, r1l;

    int checks = 0;
    int errors = 0;
    lq_t got;

    always #2 clk = ~clk;

    spf_gen u_dut (
        .clk(clk), .rst_n(rst_n), .dmd_valid_i(dmd_valid), .dmd_line_i(dmd_line),
        .zone_map_i(zmap), .pf_as_acc_i(pf_acc), .degree_i(degree),
        .req0_valid_o(r0v), .req0_line_o(r0l), .req1_valid_o(r1v), .req1_line_o(r1l)
    );

    task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] put(input logic [2*W-1:0] m, input int pos, input logic [1:0] s);
        m[2*pos +: 2] = s;
        return m;
    endfunction

    // Caller stands at a negedge; returns at the negedge where the new set is visible.
    task automatic demand(input logic [LW-1:0] line, input logic [2*W-1:0] m, input logic pf, input logic [DW-1:0] deg);
        dmd_valid = 1'b1;
        dmd_line  = line;
        zmap      = m;
        pf_acc    = pf;
        degree    = deg;
        @(negedge clk);
        dmd_valid = 1'b0;
        zmap      = '0;
        pf_acc    = 1'b0;
    endtask

    task automatic collect(input int cycles);
        got.delete();
        for (int c = 0; c < cycles; c++) begin
            if (r0v) got.push_back(r0l);
            if (r1v) got.push_back(r1l);
            @(negedge clk);
        end
    endtask

    task automatic expect_seq(input string req, input lq_t exp);
        chk(got.size() == exp.size(), {req, " count"}, LW'(got.size()), LW'(exp.size()));
        for (int k = 0; k < exp.size() && k < got.size(); k++)
            chk(got[k] == exp[k], req, got[k], exp[k]);
    endtask

    localparam logic [LW-1:0] D0 = 26'h1005;  // zone offset 5, window index 21
    localparam int P0 = 21;

    task automatic t_reset();
        chk(!r0v && !r1v, "R1 idle after reset", LW'({r0v, r1v}), '0);
        @(negedge clk);
        chk(!r0v && !r1v, "R1 idle second cycle", LW'({r0v, r1v}), '0);
    endtask

    task automatic t_example();
        logic [2*W-1:0] m = '0;
        m = put(m, P0 - 4, 2'b10);
        m = put(m, P0 - 2, 2'b10);
        m = put(m, P0 - 1, 2'b10);
        demand(D0, m, 1'b0, 4'd4);
        chk(r0v && r1v, "R7 pair in first cycle", LW'({r0v, r1v}), LW'(3));
        chk(r0l == D0 + 1, "R2 R6 nearest first", r0l, D0 + 1);
        chk(r1l == D0 + 2, "R2 R11 second candidate", r1l, D0 + 2);
        @(negedge clk);
        chk(!r0v && !r1v, "R7 set drained", LW'({r0v, r1v}), '0);
    endtask

    task automatic t_backward();
        logic [2*W-1:0] m = '0;
        m = put(m, P0 + 3, 2'b10);
        m = put(m, P0 + 6, 2'b11);
        demand(D0, m, 1'b0, 4'd4);
        collect(3);
        expect_seq("R3 backward stride", '{D0 - 3});
    endtask

    task automatic t_target_busy();
        logic [2*W-1:0] m = '0;
        m = put(m, P0 - 4, 2'b10);
        m = put(m, P0 - 2, 2'b10);
        m = put(m, P0 - 1, 2'b10);
        m = put(m, P0 + 1, 2'b01);
        demand(D0, m, 1'b0, 4'd4);
        collect(3);
        expect_seq("R4 busy target skipped", '{D0 + 2});
    endtask

    task automatic t_pf_mode();
        logic [2*W-1:0] m = '0;
        m = put(m, P0 - 1, 2'b01);
        m = put(m, P0 - 2, 2'b01);
        demand(D0, m, 1'b0, 4'd4);
        collect(3);
        expect_seq("R5 prefetched ignored when off", '{});
        demand(D0, m, 1'b1, 4'd4);
        collect(3);
        expect_seq("R5 prefetched counted when on", '{D0 + 1});
    endtask

    function automatic logic [2*W-1:0] run_map();
        logic [2*W-1:0] m = '0;
        for (int k = 1; k <= 16; k++) m = put(m, P0 - k, 2'b10);
        return m;
    endfunction

    task automatic t_degree();
        demand(D0, run_map(), 1'b0, 4'd5);
        collect(2);
        chk(r0v && !r1v, "R8 odd budget ends mid-pair", LW'({r0v, r1v}), LW'(2));
        collect(3);
        expect_seq("R8 last of five", '{D0 + 5});
        demand(D0, run_map(), 1'b0, 4'd15);
        collect(6);
        expect_seq("R6 R7 full ordered drain", '{D0+1, D0+2, D0+3, D0+4, D0+5, D0+6, D0+7, D0+8});
        demand(D0, run_map(), 1'b0, 4'd0);
        collect(3);
        expect_seq("R8 zero degree", '{});
    endtask

    task automatic t_discard();
        logic [2*W-1:0] mb = '0;
        logic [LW-1:0] b = 26'h2005;
        mb = put(mb, P0 + 3, 2'b10);
        mb = put(mb, P0 + 6, 2'b10);
        demand(D0, run_map(), 1'b0, 4'd15);
        chk(r0v && r0l == D0 + 1, "R9 old set issuing", r0l, D0 + 1);
        demand(b, mb, 1'b0, 4'd4);
        collect(4);
        expect_seq("R9 old candidates discarded", '{b - 3});
    endtask

    task automatic t_window();
        logic [2*W-1:0] m = '0;
        logic [LW-1:0] d = 26'h300F;  // window index 31
        for (int k = 32; k < W; k++) m = put(m, k, 2'b10);
        demand(d, m, 1'b0, 4'd15);
        collect(6);
        expect_seq("R10 strides past window dropped", '{d-1, d-2, d-3, d-4, d-5, d-6, d-7, d-8});
    endtask

    task automatic t_wrap();
        logic [2*W-1:0] m = '0;
        m = put(m, 30, 2'b10);
        m = put(m, 29, 2'b10);
        demand(26'h3FFFFFF, m, 1'b0, 4'd2);
        collect(2);
        expect_seq("R11 forward wrap", '{26'h0});
        m = '0;
        m = put(m, 17, 2'b10);
        m = put(m, 18, 2'b10);
        demand(26'h0, m, 1'b0, 4'd2);
        collect(2);
        expect_seq("R11 backward wrap", '{26'h3FFFFFF});
    endtask

    initial begin
        fork
            begin
                rst_n = 1'b0; dmd_valid = 1'b0; dmd_line = '0; zmap = '0; pf_acc = 1'b0; degree = '0;
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_example();
                t_backward();
                t_target_busy();
                t_pf_mode();
                t_degree();
                t_discard();
                t_window();
                t_wrap();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule